// File: doc/BRIEF.md
# Hot-Plug Interrupt Locator and Aggregator

This block collects the pending interrupt sources of a hot-plug controller into one locator word and turns that word into an interrupt request. Each slot keeps a 5-bit event latch and a 7-bit disable mask. The controller itself keeps a command-detected flag, an arbiter-detected flag and four disable bits. A slot raises its locator bit when any of its latched events is not masked. Locator bit 0 belongs to the command source, so slot `s` reports on bit `s+1`, its logical number.

The locator is reduced to a single level, which a global disable bit can suppress. The block can signal that level in two ways. With message signalling off, it drives the level on a wire output. With message signalling on, it emits a one-cycle pulse each time the level differs from the last level it requested. A restore input clears the remembered requested level, so a condition that is still pending after a state reload produces a new pulse.

Event latches and detected flags are set by pulses from the slot state logic and cleared by write-one-to-clear strobes. Register decode is done outside this block.

Top module: `hp_irq_locator`

## Requirements
- R1: After reset, control disable bits [3:0] read 1, both detected flags read 0, every slot mask reads 7'h7F, every event latch reads 0, and `locator_o`, `int_level_o`, `intx_o` and `msg_o` are 0.
- R2: Slot event latch bits are presence=bit0, isolated fault=bit1, button=bit2, latch=bit3 and connected fault=bit4. A 1 on `ev_set_i[s*5+b]` sets bit b. With `slot_wr_i[s]` high, a 1 on `slot_clr_i[b]` clears bit b. If a set and a clear reach the same bit in one cycle, the set wins.
- R3: With `slot_wr_i[s]` high, `slot_mask_i` loads slot s's 7-bit mask. Mask bits 5 and 6 are stored but have no effect on the locator.
- R4: `locator_o[s+1]` is 1 exactly when (event latch & ~mask[4:0]) of slot s is non-zero.
- R5: `locator_o[0]` is 1 exactly when command-detected (control bit 16) is 1 and command-interrupt-disable (control bit 2) is 0.
- R6: Control bits [3:0] are read/write through `ctl_wr_i`/`ctl_wdata_i`. Bit 16 is set by `cmd_done_i` and bit 17 by `arb_err_i`. Both are cleared by writing 1 to them, and a set beats a clear in the same cycle. All other control bits read 0.
- R7: `int_level_o` is 1 exactly when global interrupt-disable (control bit 0) is 0 and the locator is non-zero.
- R8: A strobe sampled on clock edge k updates the stored latches, masks and control bits on edge k. `locator_o`, `int_level_o`, `intx_o` and `msg_o` reflect that update on edge k+1.
- R9: With `msi_en_i` low, `intx_o` follows the level and `msg_o` stays 0.
- R10: With `msi_en_i` high, `intx_o` is 0. `msg_o` pulses for exactly one cycle whenever the level differs from the stored requested level. The stored requested level tracks the level in both modes.
- R11: `restore_i` forces the stored requested level to 0. If the level is still 1, the next cycle produces a new message pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_set_i | input | NSLOTS*5 | Per-slot event set pulses |
| slot_wr_i | input | NSLOTS | Per-slot register write strobe |
| slot_clr_i | input | 5 | Event latch write-one-to-clear data |
| slot_mask_i | input | 7 | Slot disable mask write data |
| ctl_wr_i | input | 1 | Control word write strobe |
| ctl_wdata_i | input | 32 | Control word write data |
| cmd_done_i | input | 1 | Sets command-detected |
| arb_err_i | input | 1 | Sets arbiter-detected |
| msi_en_i | input | 1 | Message signalling enable |
| restore_i | input | 1 | Clears stored requested level |
| slot_latch_o | output | NSLOTS*5 | Event latches, slot 0 in low bits |
| slot_mask_o | output | NSLOTS*7 | Slot masks, slot 0 in low bits |
| ctl_o | output | 32 | Control word readback |
| locator_o | output | NSLOTS+1 | Interrupt locator |
| int_level_o | output | 1 | Computed interrupt level |
| intx_o | output | 1 | Wire interrupt |
| msg_o | output | 1 | One-cycle message pulse |

## Verification
Some relations are checked by assertions on every cycle. These are: locator bit 0 and slot 0's bit against the previous cycle's stored state, the level against the disable bit and the locator, the wire interrupt against the mode, message pulses only in message mode, and the write-one-to-clear behaviour of slot 0 and of command-detected. Other behaviour only shows in the bench's scenarios. That covers set-versus-clear priority, the inert mask bits, the exact cycle at which each output moves, a pulse lasting only one cycle on both rising and falling level, and a new pulse after a restore while the level stays high.

// File: rtl/hp_irq_pkg.sv
package hp_irq_pkg;
  localparam int EVW  = 5;
  localparam int MSKW = 7;
  localparam int CTLW = 32;

  localparam int CTL_INT_DIS      = 0;
  localparam int CTL_SERR_DIS     = 1;
  localparam int CTL_CMD_INT_DIS  = 2;
  localparam int CTL_ARB_SERR_DIS = 3;
  localparam int CTL_CMD_DET      = 16;
  localparam int CTL_ARB_DET      = 17;

  localparam logic [MSKW-1:0] MASK_RST = 7'h7F;
  localparam logic [3:0]      DIS_RST  = 4'hF;

  // next value of a sticky flag group: clear by one-writes, set wins
  function automatic logic [EVW-1:0] latch_next(logic [EVW-1:0] cur,
                                                logic [EVW-1:0] clr,
                                                logic [EVW-1:0] set);
    return (cur & ~clr) | set;
  endfunction

  function automatic logic flag_next(logic cur, logic clr, logic set);
    return (cur & ~clr) | set;
  endfunction

  // a slot is pending when any unmasked event is latched
  function automatic logic slot_pending(logic [EVW-1:0] ev, logic [EVW-1:0] dis);
    return |(ev & ~dis);
  endfunction

  function automatic logic cmd_pending(logic det, logic dis);
    return det & ~dis;
  endfunction
endpackage

// File: rtl/hp_slot_bank.sv
module hp_slot_bank
  import hp_irq_pkg::*;
#(
  parameter int NSLOTS = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NSLOTS*EVW-1:0]  ev_set_i,
  input  logic [NSLOTS-1:0]      slot_wr_i,
  input  logic [EVW-1:0]         slot_clr_i,
  input  logic [MSKW-1:0]        slot_mask_i,
  output logic [NSLOTS*EVW-1:0]  latch_o,
  output logic [NSLOTS*MSKW-1:0] mask_o,
  output logic [NSLOTS-1:0]      pend_o
);
  for (genvar s = 0; s < NSLOTS; s++) begin : g_slot
    logic [EVW-1:0]  lat_q;
    logic [MSKW-1:0] msk_q;
    logic [EVW-1:0]  clr_eff;

    assign clr_eff = slot_wr_i[s] ? slot_clr_i : '0;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lat_q <= '0;
        msk_q <= MASK_RST;
      end else begin
        lat_q <= latch_next(lat_q, clr_eff, ev_set_i[s*EVW +: EVW]);
        if (slot_wr_i[s]) msk_q <= slot_mask_i;
      end
    end

    assign latch_o[s*EVW +: EVW]   = lat_q;
    assign mask_o[s*MSKW +: MSKW]  = msk_q;
    assign pend_o[s]               = slot_pending(lat_q, msk_q[EVW-1:0]);
  end
endmodule

// File: rtl/hp_ctl_reg.sv
module hp_ctl_reg
  import hp_irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ctl_wr_i,
  input  logic [CTLW-1:0] ctl_wdata_i,
  input  logic            cmd_done_i,
  input  logic            arb_err_i,
  output logic [CTLW-1:0] ctl_o,
  output logic            int_dis_o,
  output logic            cmd_pend_o
);
  logic [3:0] dis_q;
  logic       cmd_det_q;
  logic       arb_det_q;
  logic       clr_cmd;
  logic       clr_arb;
  logic       unused_wbits;

  assign clr_cmd      = ctl_wr_i & ctl_wdata_i[CTL_CMD_DET];
  assign clr_arb      = ctl_wr_i & ctl_wdata_i[CTL_ARB_DET];
  assign unused_wbits = ^{ctl_wdata_i[CTLW-1:CTL_ARB_DET+1],
                          ctl_wdata_i[CTL_CMD_DET-1:4]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dis_q     <= DIS_RST;
      cmd_det_q <= 1'b0;
      arb_det_q <= 1'b0;
    end else begin
      if (ctl_wr_i) dis_q <= ctl_wdata_i[3:0];
      cmd_det_q <= flag_next(cmd_det_q, clr_cmd, cmd_done_i);
      arb_det_q <= flag_next(arb_det_q, clr_arb, arb_err_i);
    end
  end

  always_comb begin
    ctl_o              = '0;
    ctl_o[3:0]         = dis_q;
    ctl_o[CTL_CMD_DET] = cmd_det_q;
    ctl_o[CTL_ARB_DET] = arb_det_q;
  end

  assign int_dis_o  = dis_q[CTL_INT_DIS];
  assign cmd_pend_o = cmd_pending(cmd_det_q, dis_q[CTL_CMD_INT_DIS]);
endmodule

// File: rtl/hp_irq_agg.sv
module hp_irq_agg #(
  parameter int NSLOTS = 4,
  localparam int LOCW  = NSLOTS + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSLOTS-1:0] pend_i,
  input  logic              cmd_pend_i,
  input  logic              int_dis_i,
  input  logic              msi_en_i,
  input  logic              restore_i,
  output logic [LOCW-1:0]   locator_o,
  output logic              level_o,
  output logic              intx_o,
  output logic              msg_o
);
  logic [LOCW-1:0] loc_next;
  logic            lvl_next;
  logic            req_q;
  logic            lvl_change;

  assign loc_next   = {pend_i, cmd_pend_i};
  assign lvl_next   = ~int_dis_i & (|loc_next);
  assign lvl_change = lvl_next ^ req_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locator_o <= '0;
      level_o   <= 1'b0;
      intx_o    <= 1'b0;
      msg_o     <= 1'b0;
      req_q     <= 1'b0;
    end else begin
      locator_o <= loc_next;
      level_o   <= lvl_next;
      intx_o    <= lvl_next & ~msi_en_i;
      msg_o     <= msi_en_i & lvl_change;
      req_q     <= restore_i ? 1'b0 : lvl_next;
    end
  end
endmodule

// File: rtl/hp_irq_locator.sv
module hp_irq_locator
  import hp_irq_pkg::*;
#(
  parameter int NSLOTS = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NSLOTS*5-1:0]    ev_set_i,
  input  logic [NSLOTS-1:0]      slot_wr_i,
  input  logic [4:0]             slot_clr_i,
  input  logic [6:0]             slot_mask_i,
  input  logic                   ctl_wr_i,
  input  logic [31:0]            ctl_wdata_i,
  input  logic                   cmd_done_i,
  input  logic                   arb_err_i,
  input  logic                   msi_en_i,
  input  logic                   restore_i,
  output logic [NSLOTS*5-1:0]    slot_latch_o,
  output logic [NSLOTS*7-1:0]    slot_mask_o,
  output logic [31:0]            ctl_o,
  output logic [NSLOTS:0]        locator_o,
  output logic                   int_level_o,
  output logic                   intx_o,
  output logic                   msg_o
);
  logic [NSLOTS-1:0] slot_pend;
  logic              cmd_pend;
  logic              int_dis;

  hp_slot_bank #(.NSLOTS(NSLOTS)) u_bank (
    .clk         (clk),
    .rst_n       (rst_n),
    .ev_set_i    (ev_set_i),
    .slot_wr_i   (slot_wr_i),
    .slot_clr_i  (slot_clr_i),
    .slot_mask_i (slot_mask_i),
    .latch_o     (slot_latch_o),
    .mask_o      (slot_mask_o),
    .pend_o      (slot_pend)
  );

  hp_ctl_reg u_ctl (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctl_wr_i    (ctl_wr_i),
    .ctl_wdata_i (ctl_wdata_i),
    .cmd_done_i  (cmd_done_i),
    .arb_err_i   (arb_err_i),
    .ctl_o       (ctl_o),
    .int_dis_o   (int_dis),
    .cmd_pend_o  (cmd_pend)
  );

  hp_irq_agg #(.NSLOTS(NSLOTS)) u_agg (
    .clk        (clk),
    .rst_n      (rst_n),
    .pend_i     (slot_pend),
    .cmd_pend_i (cmd_pend),
    .int_dis_i  (int_dis),
    .msi_en_i   (msi_en_i),
    .restore_i  (restore_i),
    .locator_o  (locator_o),
    .level_o    (int_level_o),
    .intx_o     (intx_o),
    .msg_o      (msg_o)
  );
endmodule

// File: rtl/hp_irq_locator_chk.sv
module hp_irq_locator_chk #(
  parameter int NSLOTS = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NSLOTS*5-1:0] ev_set_i,
  input logic [NSLOTS-1:0]   slot_wr_i,
  input logic [4:0]          slot_clr_i,
  input logic                ctl_wr_i,
  input logic [31:0]         ctl_wdata_i,
  input logic                cmd_done_i,
  input logic                msi_en_i,
  input logic [NSLOTS*5-1:0] slot_latch_o,
  input logic [NSLOTS*7-1:0] slot_mask_o,
  input logic [31:0]         ctl_o,
  input logic [NSLOTS:0]     locator_o,
  input logic                int_level_o,
  input logic                intx_o,
  input logic                msg_o
);
  // R5
  loc_cmd_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locator_o[0] == $past(ctl_o[16] && !ctl_o[2]));

  // R4
  loc_slot0_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locator_o[1] == $past(|(slot_latch_o[4:0] & ~slot_mask_o[4:0])));

  // R7
  level_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int_level_o == ($past(!ctl_o[0]) && (locator_o != '0)));

  // R9
  intx_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(msi_en_i) |-> (intx_o == int_level_o && !msg_o));

  // R10
  intx_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(msi_en_i) |-> !intx_o);

  // R2
  latch_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_wr_i[0] && slot_clr_i[0] && !ev_set_i[0]) |=> !slot_latch_o[0]);

  // R6
  cmd_det_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr_i && ctl_wdata_i[16] && !cmd_done_i) |=> !ctl_o[16]);
endmodule

bind hp_irq_locator hp_irq_locator_chk #(.NSLOTS(NSLOTS)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ev_set_i     (ev_set_i),
  .slot_wr_i    (slot_wr_i),
  .slot_clr_i   (slot_clr_i),
  .ctl_wr_i     (ctl_wr_i),
  .ctl_wdata_i  (ctl_wdata_i),
  .cmd_done_i   (cmd_done_i),
  .msi_en_i     (msi_en_i),
  .slot_latch_o (slot_latch_o),
  .slot_mask_o  (slot_mask_o),
  .ctl_o        (ctl_o),
  .locator_o    (locator_o),
  .int_level_o  (int_level_o),
  .intx_o       (intx_o),
  .msg_o        (msg_o)
);

// File: tb/test_hp_irq_locator.sv
module test_hp_irq_locator;
  localparam int N = 4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [N*5-1:0]  ev_set_i = '0;
  logic [N-1:0]    slot_wr_i = '0;
  logic [4:0]      slot_clr_i = '0;
  logic [6:0]      slot_mask_i = '0;
  logic            ctl_wr_i = 1'b0;
  logic [31:0]     ctl_wdata_i = '0;
  logic            cmd_done_i = 1'b0;
  logic            arb_err_i = 1'b0;
  logic            msi_en_i = 1'b0;
  logic            restore_i = 1'b0;
  logic [N*5-1:0]  slot_latch_o;
  logic [N*7-1:0]  slot_mask_o;
  logic [31:0]     ctl_o;
  logic [N:0]      locator_o;
  logic            int_level_o;
  logic            intx_o;
  logic            msg_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  hp_irq_locator #(.NSLOTS(N)) i_hp_irq_locator (.*);

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic release_all();
    ev_set_i = '0; slot_wr_i = '0; slot_clr_i = '0; slot_mask_i = '0;
    ctl_wr_i = 1'b0; ctl_wdata_i = '0; cmd_done_i = 1'b0;
    arb_err_i = 1'b0; restore_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1", "ctl", ctl_o, 32'h0000_000F);
    chk("R1", "masks", 32'(slot_mask_o), 32'h0FFF_FFFF);
    chk("R1", "latches", 32'(slot_latch_o), 32'h0);
    chk("R1", "outputs", 32'({locator_o, int_level_o, intx_o, msg_o}), 32'h0);
  endtask

  task automatic t_latch_masked();
    ev_set_i[5 +: 5] = 5'h05;             // slot1 presence+button
    tick(); release_all();
    chk("R2", "slot1 latch set", 32'(slot_latch_o[5 +: 5]), 32'h05);
    tick();
    chk("R4", "all masked locator", 32'(locator_o), 32'h0);
  endtask

  task automatic t_unmask();
    slot_wr_i = 4'b0010; slot_mask_i = 7'h00;
    tick(); release_all();
    chk("R3", "slot1 mask", 32'(slot_mask_o[7 +: 7]), 32'h0);
    tick();
    chk("R4", "slot1 locator", 32'(locator_o), 32'h04);
    chk("R7", "global disable holds level", 32'(int_level_o), 32'h0);
  endtask

  task automatic t_enable_level();
    ctl_wr_i = 1'b1; ctl_wdata_i = 32'h0;
    tick(); release_all();
    chk("R6", "disables cleared", ctl_o, 32'h0);
    chk("R8", "level not yet", 32'(int_level_o), 32'h0);
    tick();
    chk("R7", "level raised", 32'(int_level_o), 32'h1);
    chk("R9", "intx follows", 32'(intx_o), 32'h1);
    chk("R9", "no message", 32'(msg_o), 32'h0);
  endtask

  task automatic t_cmd_source();
    cmd_done_i = 1'b1;
    tick(); release_all();
    chk("R6", "cmd detected", ctl_o, 32'h0001_0000);
    tick();
    chk("R5", "cmd locator bit", 32'(locator_o), 32'h05);
    ctl_wr_i = 1'b1; ctl_wdata_i = 32'h4;
    tick(); release_all(); tick();
    chk("R5", "cmd bit disabled", 32'(locator_o), 32'h04);
  endtask

  task automatic t_timing_mask_high();
    slot_wr_i = 4'b0001; slot_mask_i = 7'h60; ev_set_i[3] = 1'b1;
    tick(); release_all();
    chk("R2", "slot0 latch", 32'(slot_latch_o[4:0]), 32'h08);
    chk("R8", "locator lags", 32'(locator_o), 32'h04);
    tick();
    chk("R3", "mask bits 6:5 inert", 32'(locator_o), 32'h06);
  endtask

  task automatic t_latch_w1c();
    slot_wr_i = 4'b0010; slot_clr_i = 5'h04;
    tick(); release_all();
    chk("R2", "button cleared", 32'(slot_latch_o[5 +: 5]), 32'h01);
    slot_wr_i = 4'b0010; slot_clr_i = 5'h04; ev_set_i[7] = 1'b1;
    tick(); release_all();
    chk("R2", "set beats clear", 32'(slot_latch_o[5 +: 5]), 32'h05);
  endtask

  task automatic t_ctl_w1c();
    ctl_wr_i = 1'b1; ctl_wdata_i = 32'h0001_0004; cmd_done_i = 1'b1;
    tick(); release_all();
    chk("R6", "cmd set beats clear", ctl_o, 32'h0001_0004);
    arb_err_i = 1'b1;
    tick(); release_all();
    chk("R6", "arb detected", ctl_o, 32'h0003_0004);
    ctl_wr_i = 1'b1; ctl_wdata_i = 32'h0012_0014;
    tick(); release_all();
    chk("R6", "arb cleared, spare bits zero", ctl_o, 32'h0001_0004);
    ctl_wr_i = 1'b1; ctl_wdata_i = 32'h0001_0004;
    tick(); release_all();
    chk("R6", "cmd cleared", ctl_o, 32'h0000_0004);
  endtask

  task automatic t_message();
    slot_wr_i = 4'b0011; slot_clr_i = 5'h1F; slot_mask_i = 7'h00;
    tick(); release_all(); tick();
    chk("R7", "all clear level", 32'(int_level_o), 32'h0);
    chk("R9", "intx low", 32'(intx_o), 32'h0);
    msi_en_i = 1'b1;
    ev_set_i[0] = 1'b1;
    tick(); release_all(); tick();
    chk("R10", "rise pulse", 32'(msg_o), 32'h1);
    chk("R10", "intx quiet", 32'(intx_o), 32'h0);
    tick();
    chk("R10", "pulse one cycle", 32'(msg_o), 32'h0);
    restore_i = 1'b1;
    tick(); release_all();
    chk("R11", "no pulse during restore", 32'(msg_o), 32'h0);
    tick();
    chk("R11", "fresh pulse", 32'(msg_o), 32'h1);
    tick();
    chk("R11", "fresh pulse ends", 32'(msg_o), 32'h0);
    slot_wr_i = 4'b0001; slot_clr_i = 5'h01;
    tick(); release_all(); tick();
    chk("R10", "fall pulse", 32'(msg_o), 32'h1);
    chk("R10", "level low", 32'(int_level_o), 32'h0);
    tick();
    chk("R10", "fall pulse ends", 32'(msg_o), 32'h0);
  endtask

  initial begin
    repeat (3) tick();
    t_reset();
    rst_n = 1'b1;
    tick();
    chk("R1", "idle after reset", 32'({locator_o, int_level_o}), 32'h0);
    t_latch_masked();
    t_unmask();
    t_enable_level();
    t_cmd_source();
    t_timing_mask_high();
    t_latch_w1c();
    t_ctl_w1c();
    t_message();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule